// File: doc/BRIEF.md
# Base-Index Effective Address Generator

This unit forms the 64-bit effective address of a memory-reference instruction in one pipeline stage. A request carries a base register number, an index register number, a 20-bit displacement field and a format flag. The flag tells a short-form memory reference apart from an extended-form one. The block drives two read selects into an integer register file of 32 entries by 64 bits and receives both values back in the same cycle. It then adds the base value, the index value and the zero-extended displacement.

The base register that is named fixes the size of the region it can reach, and so how many displacement bits count. Register 16 is special. It points at a table of 64-bit pointers, and its displacement field gives a pointer slot number, not a byte offset. The unit also checks whether the base register is legal for the format, whether the index register is legal, and whether the table slot is in range. It reports each of these as a separate error flag.

Requests enter through a valid/ready handshake. The result, with its error flags, comes out of a register one cycle later, under a valid/ready handshake of its own. The result is held unchanged while the consumer stalls.

Top module: `ea_unit`

## Requirements
- R1: After reset `rsp_valid` is 0 and `req_ready` is 1.
- R2: For a legal request, `rsp_addr` equals base value + index value + offset, where the offset is the masked, zero-extended displacement (R4) or the scaled table offset (R5).
- R3: An index number of 0 adds nothing. The contents of register 0 never reach the address.
- R4: Displacement bits above the width of the base's region are ignored. The widths are 16 bits for bases 25–31, 15 bits for base 24, 12 bits for bases 17–23, and 20 bits for bases 9–15.
- R5: With base 16 in short form, the slot number is `req_disp[8:0]` and the offset is that slot number times 8. Higher displacement bits are ignored. `rsp_err_range` is 1 exactly when the slot number exceeds 383.
- R6: An index number from 8 to 31 sets `rsp_err_index`. Index numbers 0 to 7 leave it at 0.
- R7: In short form (`req_fmt_ext`=0) the legal bases are 16–31. In extended form (`req_fmt_ext`=1) the legal bases are 9–15. Any other base sets `rsp_err_base`. The request still produces one output beat, and `rsp_addr` is then don't-care.
- R8: `req_ready` is 1 when the output register is empty or is being drained this cycle. An accepted request appears on `rsp_valid` at the next clock edge.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the address and all error flags stay unchanged, and no new request is taken.
- R10: The address sum wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_fmt_ext | input | 1 | 1 = extended memory-reference form |
| req_base | input | 5 | Base register number |
| req_index | input | 5 | Index register number, 0 = none |
| req_disp | input | 20 | Displacement field |
| rf_base_sel | output | 5 | Register file read select for the base |
| rf_base_data | input | 64 | Base register value, same cycle |
| rf_index_sel | output | 5 | Register file read select for the index |
| rf_index_data | input | 64 | Index register value, same cycle |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 64 | Effective address |
| rsp_err_base | output | 1 | Base illegal for the format |
| rsp_err_index | output | 1 | Index register illegal |
| rsp_err_range | output | 1 | Table slot above 383 |

## Verification
A wrong base classification shows up at the ports on the very next beat. It appears either as a flipped `rsp_err_base` or as an address off by the displacement bits that the wrong mask keeps or drops. The sweep over every base, index and format catches both in the cycle after the request. A fault in the output register's hold logic shows up only under stall: the address or the flags change while `rsp_valid` is high and `rsp_ready` is low, or a new request is taken into a full register. A directed stall sequence makes that visible within a few cycles.

// File: rtl/ea_pkg.sv
// Shared types and register-class constants for the effective address unit.
// Assumes a 32-entry integer register file addressed by 5-bit numbers.
package ea_pkg;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_TABLE,
        CLS_R12,
        CLS_R15,
        CLS_R16,
        CLS_R20
    } base_cls_e;

    typedef struct packed {
        logic base;
        logic index;
        logic range;
    } ea_err_t;

    localparam int IDX_HI      = 7;
    localparam int EXT_LO      = 9;
    localparam int EXT_HI      = 15;
    localparam int TBL_REG     = 16;
    localparam int R12_LO      = 17;
    localparam int R12_HI      = 23;
    localparam int R15_REG     = 24;
    localparam int R16_LO      = 25;
    localparam int W_R12       = 12;
    localparam int W_R15       = 15;
    localparam int W_R16       = 16;
    localparam int W_R20       = 20;

endpackage

// File: rtl/ea_classify.sv
// Decodes the base and index register numbers into a base region class and
// legality flags. Assumes the format flag picks short (0) or extended (1) form.
module ea_classify
    import ea_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              fmt_ext,
    input  logic [REG_AW-1:0] base_num,
    input  logic [REG_AW-1:0] index_num,
    output base_cls_e         cls,
    output logic              base_bad,
    output logic              index_bad,
    output logic              index_used
);

    localparam logic [REG_AW-1:0] L_IDX_HI  = REG_AW'(IDX_HI);
    localparam logic [REG_AW-1:0] L_EXT_LO  = REG_AW'(EXT_LO);
    localparam logic [REG_AW-1:0] L_EXT_HI  = REG_AW'(EXT_HI);
    localparam logic [REG_AW-1:0] L_TBL     = REG_AW'(TBL_REG);
    localparam logic [REG_AW-1:0] L_R12_LO  = REG_AW'(R12_LO);
    localparam logic [REG_AW-1:0] L_R12_HI  = REG_AW'(R12_HI);
    localparam logic [REG_AW-1:0] L_R15     = REG_AW'(R15_REG);
    localparam logic [REG_AW-1:0] L_R16_LO  = REG_AW'(R16_LO);

    // Map base register number and format to a region class.
    always_comb begin
        cls = CLS_NONE;
        if (fmt_ext) begin
            if (base_num >= L_EXT_LO && base_num <= L_EXT_HI) cls = CLS_R20;
        end else if (base_num == L_TBL) begin
            cls = CLS_TABLE;
        end else if (base_num >= L_R12_LO && base_num <= L_R12_HI) begin
            cls = CLS_R12;
        end else if (base_num == L_R15) begin
            cls = CLS_R15;
        end else if (base_num >= L_R16_LO) begin
            cls = CLS_R16;
        end
    end

    // Legality of the base and index choices.
    always_comb begin
        base_bad   = (cls == CLS_NONE);
        index_bad  = (index_num > L_IDX_HI);
        index_used = (index_num != '0) && !index_bad;
    end

endmodule

// File: rtl/ea_offset.sv
// Turns the displacement field into a zero-extended byte offset for the
// region class, and checks the pointer-table slot bound.
// Assumes DISP_W is at least the widest region width.
module ea_offset
    import ea_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int DISP_W      = 20,
    parameter int TBL_ENTRIES = 384,
    parameter int PTR_SHIFT   = 3
) (
    input  base_cls_e         cls,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] offset,
    output logic              range_bad
);

    localparam int TBL_IW = $clog2(TBL_ENTRIES);
    localparam logic [TBL_IW-1:0] L_TBL_LAST = TBL_IW'(TBL_ENTRIES - 1);

    logic [TBL_IW-1:0] slot;
    logic [DISP_W-1:0] disp_m;

    // Build a mask of the low w bits of the displacement.
    function automatic logic [DISP_W-1:0] low_mask(input int w);
        low_mask = (DISP_W'(1) << w) - DISP_W'(1);
    endfunction

    // Keep only the displacement bits the region can reach.
    always_comb begin
        case (cls)
            CLS_R12: disp_m = disp & low_mask(W_R12);
            CLS_R15: disp_m = disp & low_mask(W_R15);
            CLS_R16: disp_m = disp & low_mask(W_R16);
            CLS_R20: disp_m = disp & low_mask(W_R20);
            default: disp_m = '0;
        endcase
    end

    // Select the table-scaled or plain offset and flag an out-of-range slot.
    always_comb begin
        slot      = disp[TBL_IW-1:0];
        range_bad = (cls == CLS_TABLE) && (slot > L_TBL_LAST);
        if (cls == CLS_TABLE) offset = ADDR_W'(slot) << PTR_SHIFT;
        else                  offset = ADDR_W'(disp_m);
    end

endmodule

// File: rtl/ea_stage.sv
// One-entry pipeline register with valid/ready on both sides.
// Assumes the consumer may stall indefinitely; the entry then holds.
module ea_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    logic         full_q;
    logic [W-1:0] data_q;

    // Space exists when empty or when the held entry leaves this cycle.
    always_comb in_ready = !full_q || out_ready;

    // Track occupancy and load new entries on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (in_ready) begin
            full_q <= in_valid;
            if (in_valid) data_q <= in_data;
        end
    end

    assign out_valid = full_q;
    assign out_data  = data_q;

endmodule

// File: rtl/ea_unit.sv
// Base-index effective address unit: reads base and index values from the
// register file in the request cycle, adds the masked displacement, and
// registers the address with its error flags. Assumes the register file
// answers its read selects combinationally.
module ea_unit
    import ea_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int REG_AW      = 5,
    parameter int DISP_W      = 20,
    parameter int TBL_ENTRIES = 384,
    parameter int PTR_SHIFT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_fmt_ext,
    input  logic [REG_AW-1:0] req_base,
    input  logic [REG_AW-1:0] req_index,
    input  logic [DISP_W-1:0] req_disp,
    output logic [REG_AW-1:0] rf_base_sel,
    input  logic [ADDR_W-1:0] rf_base_data,
    output logic [REG_AW-1:0] rf_index_sel,
    input  logic [ADDR_W-1:0] rf_index_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_err_base,
    output logic              rsp_err_index,
    output logic              rsp_err_range
);

    localparam int PAY_W = ADDR_W + $bits(ea_err_t);

    base_cls_e         cls;
    logic              base_bad, index_bad, index_used, range_bad;
    logic [ADDR_W-1:0] offset, sum;
    ea_err_t           err_d, err_q;
    logic [PAY_W-1:0]  pay_d, pay_q;

    assign rf_base_sel  = req_base;
    assign rf_index_sel = req_index;

    ea_classify #(.REG_AW(REG_AW)) u_cls (
        .fmt_ext    (req_fmt_ext),
        .base_num   (req_base),
        .index_num  (req_index),
        .cls        (cls),
        .base_bad   (base_bad),
        .index_bad  (index_bad),
        .index_used (index_used)
    );

    ea_offset #(
        .ADDR_W      (ADDR_W),
        .DISP_W      (DISP_W),
        .TBL_ENTRIES (TBL_ENTRIES),
        .PTR_SHIFT   (PTR_SHIFT)
    ) u_off (
        .cls       (cls),
        .disp      (req_disp),
        .offset    (offset),
        .range_bad (range_bad)
    );

    // Three-operand address sum, wrapping at the address width.
    always_comb begin
        sum = rf_base_data + (index_used ? rf_index_data : '0) + offset;
        err_d.base  = base_bad;
        err_d.index = index_bad;
        err_d.range = range_bad;
        pay_d = {sum, err_d};
    end

    ea_stage #(.W(PAY_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_data   (pay_d),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_data  (pay_q)
    );

    // Unpack the registered payload onto the response ports.
    always_comb begin
        {rsp_addr, err_q} = pay_q;
        rsp_err_base  = err_q.base;
        rsp_err_index = err_q.index;
        rsp_err_range = err_q.range;
    end

endmodule

// File: rtl/ea_unit_chk.sv
// Protocol and arithmetic checks for ea_unit, bound to every instance.
module ea_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_fmt_ext,
    input logic [4:0]  req_base,
    input logic [4:0]  req_index,
    input logic [19:0] req_disp,
    input logic [63:0] rf_base_data,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [63:0] rsp_addr,
    input logic        rsp_err_base,
    input logic        rsp_err_index,
    input logic        rsp_err_range
);

    logic acc;
    assign acc = req_valid && req_ready;

    p_accept_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)
            && $stable(rsp_err_base) && $stable(rsp_err_index) && $stable(rsp_err_range)));

    p_full_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready);

    p_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_index > 5'd7) |=> rsp_err_index);

    p_ext_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_fmt_ext && (req_base < 5'd9 || req_base > 5'd15)) |=> rsp_err_base);

    p_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_fmt_ext && req_base == 5'd16 && req_disp[8:0] > 9'd383) |=> rsp_err_range);

    p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_fmt_ext && req_base >= 5'd25 && req_index == 5'd0)
        |=> rsp_addr == $past(rf_base_data) + 64'($past(req_disp[15:0])));

    p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_fmt_ext && req_base >= 5'd17 && req_base <= 5'd23 && req_index == 5'd0)
        |=> rsp_addr == $past(rf_base_data) + 64'($past(req_disp[11:0])));

endmodule

bind ea_unit ea_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_fmt_ext   (req_fmt_ext),
    .req_base      (req_base),
    .req_index     (req_index),
    .req_disp      (req_disp),
    .rf_base_data  (rf_base_data),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_addr      (rsp_addr),
    .rsp_err_base  (rsp_err_base),
    .rsp_err_index (rsp_err_index),
    .rsp_err_range (rsp_err_range)
);

// File: tb/tb_ea_unit.sv
module tb_ea_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_fmt_ext = 1'b0;
    logic [4:0]  req_base = '0;
    logic [4:0]  req_index = '0;
    logic [19:0] req_disp = '0;
    logic [4:0]  rf_base_sel, rf_index_sel;
    logic [63:0] rf_base_data, rf_index_data;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [63:0] rsp_addr;
    logic        rsp_err_base, rsp_err_index, rsp_err_range;

    logic [63:0] regs [32];
    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_base_data  = regs[rf_base_sel];
    assign rf_index_data = regs[rf_index_sel];

    ea_unit dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_fmt_ext(req_fmt_ext), .req_base(req_base),
        .req_index(req_index), .req_disp(req_disp),
        .rf_base_sel(rf_base_sel), .rf_base_data(rf_base_data),
        .rf_index_sel(rf_index_sel), .rf_index_data(rf_index_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_err_base(rsp_err_base),
        .rsp_err_index(rsp_err_index), .rsp_err_range(rsp_err_range)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [67:0] act, input logic [67:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model built from the requirement text.
    task automatic model(input logic f, input logic [4:0] b, input logic [4:0] ix,
                         input logic [19:0] d, output logic [63:0] a,
                         output logic eb, output logic ei, output logic er);
        int w;
        logic [63:0] off;
        eb = f ? !(b >= 5'd9 && b <= 5'd15) : !(b >= 5'd16);
        ei = ix > 5'd7;
        er = !f && b == 5'd16 && d[8:0] > 9'd383;
        w  = f ? 20 : (b == 5'd24) ? 15 : (b >= 5'd25) ? 16 : 12;
        if (!f && b == 5'd16) off = 64'(d[8:0]) * 64'd8;
        else                  off = 64'(d) & ((64'd1 << w) - 64'd1);
        a = regs[b] + ((ix != 5'd0) ? regs[ix] : 64'd0) + off;
    endtask

    task automatic one_req(input logic f, input logic [4:0] b, input logic [4:0] ix,
                           input logic [19:0] d, input string tag);
        logic [63:0] ea;
        logic eb, ei, er;
        logic [67:0] act, exp;
        model(f, b, ix, d, ea, eb, ei, er);
        @(negedge clk);
        req_fmt_ext = f; req_base = b; req_index = ix; req_disp = d;
        req_valid = 1'b1; rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        act = {rsp_valid, rsp_err_base, rsp_err_index, rsp_err_range,
               (eb || ei || er) ? 64'd0 : rsp_addr};
        exp = {1'b1, eb, ei, er, (eb || ei || er) ? 64'd0 : ea};
        check(act == exp, tag, act, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] a1, a2;
        logic eb, ei, er;
        for (int i = 0; i < 32; i++)
            regs[i] = 64'h9E37_79B9_7F4A_7C15 * 64'(i + 1) ^ (64'(i) << 44);
        regs[25] = 64'hFFFF_FFFF_FFFF_FFFF;
        regs[0]  = 64'hDEAD_BEEF_0BAD_F00D;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(!rsp_valid && req_ready, "R1 reset state",
              68'({rsp_valid, req_ready}), 68'({1'b0, 1'b1}));

        // Sweep of format x base x index; tag names the deciding requirement.
        for (int f = 0; f < 2; f++)
            for (int b = 0; b < 32; b++)
                for (int ix = 0; ix < 32; ix++) begin
                    logic [19:0] d;
                    string tag;
                    d = 20'(ix * 29 + b * 977 + f * 4099);
                    model(1'(f), 5'(b), 5'(ix), d, a1, eb, ei, er);
                    if (eb)              tag = "R7 base legality";
                    else if (ei)         tag = "R6 index legality";
                    else if (b == 16)    tag = "R5 table slot";
                    else if (ix == 0)    tag = "R3 no index";
                    else                 tag = "R2 address sum";
                    one_req(1'(f), 5'(b), 5'(ix), d, tag);
                end

        // R4: all-ones displacement against every region width
        one_req(1'b0, 5'd17, 5'd0, 20'hFFFFF, "R4 mask 12");
        one_req(1'b0, 5'd24, 5'd0, 20'hFFFFF, "R4 mask 15");
        one_req(1'b0, 5'd30, 5'd0, 20'hFFFFF, "R4 mask 16");
        one_req(1'b1, 5'd9,  5'd3, 20'hFFFFF, "R4 mask 20");
        // R5: slot boundary 383 / 384 with high bits set
        one_req(1'b0, 5'd16, 5'd2, 20'hFFD7F, "R5 slot 383");
        one_req(1'b0, 5'd16, 5'd2, 20'h00180, "R5 slot 384");
        // R10: all-ones base wraps
        one_req(1'b0, 5'd25, 5'd1, 20'h00005, "R10 wrap");

        // R8 / R9: backpressure
        model(1'b0, 5'd26, 5'd2, 20'h01234, a1, eb, ei, er);
        model(1'b0, 5'd18, 5'd4, 20'h00ABC, a2, eb, ei, er);
        @(negedge clk);
        req_fmt_ext = 1'b0; req_base = 5'd26; req_index = 5'd2; req_disp = 20'h01234;
        req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk);
        req_base = 5'd18; req_index = 5'd4; req_disp = 20'h00ABC;
        check(rsp_valid && !req_ready, "R8 full register blocks input",
              68'({rsp_valid, req_ready}), 68'({1'b1, 1'b0}));
        repeat (3) @(negedge clk);
        check(rsp_valid && rsp_addr == a1, "R9 held under stall",
              {3'b0, rsp_valid, rsp_addr}, {3'b0, 1'b1, a1});
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && rsp_addr == a2, "R8 drain and refill",
              {3'b0, rsp_valid, rsp_addr}, {3'b0, 1'b1, a2});
        @(negedge clk);
        check(!rsp_valid, "R8 empties after drain",
              68'(rsp_valid), 68'(0));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule